// File: doc/BRIEF.md
# Receive Queue with Line Status

This block holds received serial characters until software reads them. It is a 16-entry first-in first-out store. Each slot holds one data byte and three per-character error marks: parity, framing and break. A character that comes in as a break is stored as a zero byte. The block also builds the 8-bit line status value that software polls. That value combines the head slot's marks, a sticky overrun indication, a summary error bit and two transmitter status bits that are passed straight through.

The deserialiser presents each finished character as a one-cycle strobe together with its byte and marks. Software consumes the head byte with a data-read strobe and acknowledges errors with a status-read strobe. A flush pulse empties the store. The fill level and a line-event level are provided so that a separate interrupt encoder can decide what to raise.

Top module: `rx_line_fifo`

## Requirements
- R1: After reset the store is empty, `head_data` is 0x00, `line_event` is 0, and with both transmitter inputs high `line_status` reads 0x60.
- R2: Characters come out in arrival order. `head_data` shows the oldest byte. `fill_level` counts the stored characters. A `data_rd` pulse removes the head. Status bit 0 is set exactly when `fill_level` is non-zero.
- R3: The store holds 16 characters. A character that arrives while the store is full, with no read in the same cycle, is discarded and the stored contents stay intact. This sets overrun, status bit 1, so a full store with clean entries reads 0xE3.
- R4: The overrun bit clears in the cycle after a `status_rd` pulse, so 0xE3 becomes 0x61. If a new character is discarded in the same cycle as the status read, overrun stays set.
- R5: A character arrival and a `data_rd` in the same cycle while the store is full perform both operations. The level stays at 16 and no overrun is raised.
- R6: Status bits 2, 3 and 4 show the parity, framing and break marks of the head entry. Each mark travels with its own character through the store.
- R7: A character marked as a break is stored as 0x00, whatever data byte came with it.
- R8: A `status_rd` pulse clears the marks of the current head entry. A framing error reading 0xE9, or a break reading 0xF1, therefore reads 0x61 afterwards.
- R9: Status bit 7 is set while overrun is set or while any stored entry still carries a mark. This includes entries behind a clean head.
- R10: A `data_rd` pulse on an empty store changes nothing, so the level stays 0 and the status stays 0x60.
- R11: A `flush` pulse empties the store and clears overrun. A character arriving in the same cycle as the flush is dropped. Afterwards the status reads 0x60 with both transmitter inputs high.
- R12: Status bit 5 follows `tx_hold_empty` and status bit 6 follows `tx_idle`.
- R13: `line_event` is high exactly when any of status bits 1 to 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_vld | input | 1 | One-cycle strobe: a received character is offered |
| char_data | input | 8 | Received byte |
| char_perr | input | 1 | Parity error mark of the offered character |
| char_ferr | input | 1 | Framing error mark of the offered character |
| char_brk | input | 1 | Break mark of the offered character |
| data_rd | input | 1 | Pops the head character |
| status_rd | input | 1 | Status acknowledge: clears overrun and the head marks |
| flush | input | 1 | Empties the store and clears overrun |
| tx_hold_empty | input | 1 | Transmit holding stage empty, shown in bit 5 |
| tx_idle | input | 1 | Transmitter fully idle, shown in bit 6 |
| head_data | output | 8 | Byte at the head, 0x00 when empty |
| line_status | output | 8 | Line status value |
| fill_level | output | 5 | Number of stored characters |
| line_event | output | 1 | Any of status bits 1 to 4 set |

## Verification
Sequences of distinct bytes are written and drained to show that order and level tracking are correct. Runs that fill the store to its limit separate three cases: a discarded arrival that raises overrun, an arrival together with a read that is absorbed without overrun, and a status read that coincides with a new discard. Mixed clean, framing, parity and break characters show that each mark follows its own character to the head. They also show that the summary bit reacts to errored entries behind a clean head, and that a status read clears only the head marks. Reads on an empty store and flushes of a store holding errors confirm that the status returns to 0x60.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       perr;
        logic       ferr;
        logic       brk;
        logic [7:0] data;
    } rxq_entry_t;

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  rxq_entry_t wr_entry,
    input  logic       rd_en,
    input  logic       clr_head,
    input  logic       flush,
    output rxq_entry_t head_entry,
    output logic       has_data,
    output logic [AW:0] level,
    output logic       any_err,
    output logic       dropped
);

    typedef struct packed {
        rxq_entry_t [DEPTH-1:0] slots;
        logic [AW-1:0]          rd_ptr;
        logic [AW-1:0]          wr_ptr;
        logic [AW:0]            count;
    } ring_t;

    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    ring_t ring_d, ring_q;
    logic  full, pop, push;
    logic [DEPTH-1:0] slot_err;

    assign full = (ring_q.count == FULL_CNT);
    assign pop  = rd_en && (ring_q.count != '0) && !flush;
    assign push = wr_en && (!full || pop) && !flush;
    assign dropped = wr_en && full && !rd_en && !flush;

    always_comb begin
        ring_d = ring_q;
        if (flush) begin
            ring_d.rd_ptr = '0;
            ring_d.wr_ptr = '0;
            ring_d.count  = '0;
        end else begin
            if (clr_head && ring_q.count != '0) begin
                ring_d.slots[ring_q.rd_ptr].perr = 1'b0;
                ring_d.slots[ring_q.rd_ptr].ferr = 1'b0;
                ring_d.slots[ring_q.rd_ptr].brk  = 1'b0;
            end
            if (push) begin
                ring_d.slots[ring_q.wr_ptr] = wr_entry;
                ring_d.wr_ptr = ring_q.wr_ptr + 1'b1;
            end
            if (pop) begin
                ring_d.rd_ptr = ring_q.rd_ptr + 1'b1;
            end
            ring_d.count = ring_q.count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [AW-1:0] offs;
        assign offs = AW'(i) - ring_q.rd_ptr;
        assign slot_err[i] = ({1'b0, offs} < ring_q.count) &&
                             (ring_q.slots[i].perr || ring_q.slots[i].ferr ||
                              ring_q.slots[i].brk);
    end

    assign has_data   = (ring_q.count != '0);
    assign head_entry = has_data ? ring_q.slots[ring_q.rd_ptr] : '0;
    assign level      = ring_q.count;
    assign any_err    = |slot_err;

endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       dropped,
    input  logic       status_rd,
    input  logic       has_data,
    input  rxq_entry_t head_entry,
    input  logic       any_err,
    input  logic       tx_hold_empty,
    input  logic       tx_idle,
    output logic [7:0] line_status,
    output logic       line_event
);

    typedef struct packed {
        logic ovr;
    } lsr_t;

    lsr_t lsr_d, lsr_q;

    always_comb begin
        lsr_d = lsr_q;
        if (flush)          lsr_d.ovr = 1'b0;
        else if (dropped)   lsr_d.ovr = 1'b1;
        else if (status_rd) lsr_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lsr_q <= '0;
        else        lsr_q <= lsr_d;
    end

    assign line_status = {lsr_q.ovr || any_err, tx_idle, tx_hold_empty,
                          head_entry.brk, head_entry.ferr, head_entry.perr,
                          lsr_q.ovr, has_data};
    assign line_event  = |line_status[4:1];

endmodule

// File: rtl/rx_line_fifo.sv
module rx_line_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        char_vld,
    input  logic [7:0]  char_data,
    input  logic        char_perr,
    input  logic        char_ferr,
    input  logic        char_brk,
    input  logic        data_rd,
    input  logic        status_rd,
    input  logic        flush,
    input  logic        tx_hold_empty,
    input  logic        tx_idle,
    output logic [7:0]  head_data,
    output logic [7:0]  line_status,
    output logic [AW:0] fill_level,
    output logic        line_event
);

    rxq_entry_t in_entry, head_entry;
    logic       has_data, any_err, dropped;

    always_comb begin
        in_entry.perr = char_perr;
        in_entry.ferr = char_ferr;
        in_entry.brk  = char_brk;
        in_entry.data = char_brk ? 8'h00 : char_data;
    end

    rxq_ring #(.DEPTH(DEPTH)) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (char_vld),
        .wr_entry  (in_entry),
        .rd_en     (data_rd),
        .clr_head  (status_rd),
        .flush     (flush),
        .head_entry(head_entry),
        .has_data  (has_data),
        .level     (fill_level),
        .any_err   (any_err),
        .dropped   (dropped)
    );

    rxq_lsr i_lsr (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .dropped      (dropped),
        .status_rd    (status_rd),
        .has_data     (has_data),
        .head_entry   (head_entry),
        .any_err      (any_err),
        .tx_hold_empty(tx_hold_empty),
        .tx_idle      (tx_idle),
        .line_status  (line_status),
        .line_event   (line_event)
    );

    assign head_data = head_entry.data;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        char_vld,
    input logic        data_rd,
    input logic        status_rd,
    input logic        flush,
    input logic [7:0]  head_data,
    input logic [7:0]  line_status,
    input logic [AW:0] fill_level
);

    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL_CNT);                                          // R3

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld && fill_level == FULL_CNT && !data_rd && !flush
        |=> line_status[1] && fill_level == FULL_CNT);                    // R3

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd && !(char_vld && fill_level == FULL_CNT && !data_rd)
        |=> !line_status[1]);                                             // R4

    AST_FULL_RW: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld && data_rd && fill_level == FULL_CNT && !flush && !line_status[1]
        |=> fill_level == FULL_CNT && !line_status[1]);                   // R5

    AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[4] |-> head_data == 8'h00);                           // R7

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_status[4:1]) |-> line_status[7]);                          // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && fill_level == '0 && !char_vld
        |=> fill_level == '0);                                            // R10

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fill_level == '0 && line_status[4:0] == 5'b0);          // R11

endmodule

bind rx_line_fifo rxq_checker #(.DEPTH(DEPTH)) i_rxq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_vld   (char_vld),
    .data_rd    (data_rd),
    .status_rd  (status_rd),
    .flush      (flush),
    .head_data  (head_data),
    .line_status(line_status),
    .fill_level (fill_level)
);

// File: tb/test_rx_line_fifo.sv
`timescale 1ns/1ps
module test_rx_line_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_vld = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       char_perr = 1'b0, char_ferr = 1'b0, char_brk = 1'b0;
    logic       data_rd = 1'b0, status_rd = 1'b0, flush = 1'b0;
    logic       tx_hold_empty = 1'b1, tx_idle = 1'b1;
    logic [7:0] head_data, line_status;
    logic [4:0] fill_level;
    logic       line_event;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_line_fifo i_rx_line_fifo (
        .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_data(char_data),
        .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
        .data_rd(data_rd), .status_rd(status_rd), .flush(flush),
        .tx_hold_empty(tx_hold_empty), .tx_idle(tx_idle),
        .head_data(head_data), .line_status(line_status),
        .fill_level(fill_level), .line_event(line_event)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic p, input logic f, input logic b);
        char_vld = 1'b1; char_data = d; char_perr = p; char_ferr = f; char_brk = b;
        @(negedge clk);
        char_vld = 1'b0; char_perr = 1'b0; char_ferr = 1'b0; char_brk = 1'b0;
    endtask

    task automatic pop();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic ack();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", line_status, 8'h60);
        chk("R1 level", fill_level, 0);
        chk("R1 head", head_data, 8'h00);
        chk("R1 event", line_event, 0);
        tx_hold_empty = 1'b0;
        #1 chk("R12 hold empty low", line_status, 8'h40);
        tx_idle = 1'b0;
        #1 chk("R12 idle low", line_status, 8'h00);
        tx_hold_empty = 1'b1;
        #1 chk("R12 hold empty only", line_status, 8'h20);
        tx_idle = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_order();
        put(8'hA1, 0, 0, 0);
        put(8'hB2, 0, 0, 0);
        put(8'hC3, 0, 0, 0);
        chk("R2 level", fill_level, 3);
        chk("R2 head first", head_data, 8'hA1);
        chk("R2 ready bit", line_status, 8'h61);
        pop();
        chk("R2 head second", head_data, 8'hB2);
        pop();
        chk("R2 head third", head_data, 8'hC3);
        pop();
        chk("R2 empty status", line_status, 8'h60);
        chk("R2 empty level", fill_level, 0);
    endtask

    task automatic t_overrun();
        int bad = 0;
        for (int i = 0; i < 16; i++) put(8'h10 + 8'(i), 0, 0, 0);
        chk("R3 full level", fill_level, 16);
        put(8'hEE, 0, 0, 0);
        chk("R3 level after drop", fill_level, 16);
        chk("R3 overrun status", line_status, 8'hE3);
        chk("R13 event on overrun", line_event, 1);
        ack();
        chk("R4 overrun cleared", line_status, 8'h61);
        chk("R13 event cleared", line_event, 0);
        for (int i = 0; i < 16; i++) begin
            if (head_data !== 8'h10 + 8'(i)) bad++;
            pop();
        end
        chk("R3 contents intact", bad, 0);
        chk("R3 drained", line_status, 8'h60);
    endtask

    task automatic t_full_rw();
        for (int i = 0; i < 16; i++) put(8'h40 + 8'(i), 0, 0, 0);
        char_vld = 1'b1; char_data = 8'h99; data_rd = 1'b1;
        @(negedge clk);
        char_vld = 1'b0; data_rd = 1'b0;
        chk("R5 level kept", fill_level, 16);
        chk("R5 no overrun", line_status, 8'h61);
        chk("R5 head advanced", head_data, 8'h41);
        for (int i = 0; i < 15; i++) pop();
        chk("R5 new byte last", head_data, 8'h99);
        pop();
        chk("R5 drained", fill_level, 0);
    endtask

    task automatic t_ovr_priority();
        for (int i = 0; i < 16; i++) put(8'(i), 0, 0, 0);
        char_vld = 1'b1; char_data = 8'h77; status_rd = 1'b1;
        @(negedge clk);
        char_vld = 1'b0; status_rd = 1'b0;
        chk("R4 drop beats ack", line_status, 8'hE3);
        char_vld = 1'b1; char_data = 8'h78; flush = 1'b1;
        @(negedge clk);
        char_vld = 1'b0; flush = 1'b0;
        chk("R11 flush status", line_status, 8'h60);
        chk("R11 flush level", fill_level, 0);
    endtask

    task automatic t_flags();
        put(8'h11, 0, 0, 0);
        put(8'h22, 0, 1, 0);
        put(8'h33, 1, 0, 0);
        chk("R9 errors behind clean head", line_status, 8'hE1);
        chk("R13 no event for clean head", line_event, 0);
        pop();
        chk("R6 framing at head", line_status, 8'hE9);
        chk("R13 event on framing", line_event, 1);
        ack();
        chk("R8 framing cleared, parity behind", line_status, 8'hE1);
        chk("R8 data kept", head_data, 8'h22);
        pop();
        chk("R6 parity at head", line_status, 8'hE5);
        ack();
        chk("R9 summary cleared", line_status, 8'h61);
        pop();
        chk("R6 drained", line_status, 8'h60);
    endtask

    task automatic t_break();
        put(8'h5A, 0, 0, 1);
        chk("R7 break byte zero", head_data, 8'h00);
        chk("R6 break status", line_status, 8'hF1);
        ack();
        chk("R8 break cleared", line_status, 8'h61);
        pop();
        chk("R7 drained", line_status, 8'h60);
    endtask

    task automatic t_empty_read();
        pop();
        chk("R10 level after empty read", fill_level, 0);
        chk("R10 status after empty read", line_status, 8'h60);
        put(8'h3C, 0, 0, 0);
        chk("R10 store still works", head_data, 8'h3C);
        pop();
    endtask

    task automatic t_flush();
        put(8'h01, 0, 1, 0);
        put(8'h02, 1, 0, 0);
        chk("R11 before flush", line_status, 8'hE9);
        do_flush();
        chk("R11 flushed status", line_status, 8'h60);
        chk("R11 flushed level", fill_level, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_overrun();
        t_full_rw();
        t_ovr_priority();
        t_flags();
        t_break();
        t_empty_read();
        t_flush();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule